// File: doc/BRIEF.md
# Hammock Selective Squash Controller

This block recovers from a mispredicted branch that opens a single-sided, simple hammock without throwing away the control-independent join context. Each branch arrives with three annotation fields: the hammock span, the join offset and the count of data-independent join instructions. The controller counts the instructions that follow the branch and captures each one that falls inside the span into a small hold queue. It tags the ones that depend on the then context.

When the branch resolves as mispredicted, every captured entry except the tagged ones is reported as squashed. The tagged dependent instructions are sent out again in program order for a second rename and issue. When the branch resolves as correct, every captured entry is purged. On a misprediction the rename map is repaired from two snapshots. If the branch had been predicted taken, fetch is also redirected to the start of the join context.

The sequencer has four states. ST_IDLE goes to ST_COLLECT when an annotated branch is accepted. ST_COLLECT goes to ST_WAIT when the last span instruction is captured. ST_COLLECT or ST_WAIT goes to ST_REPLAY on a mispredicted resolve that has tagged entries. Any other resolve returns ST_COLLECT or ST_WAIT to ST_IDLE. ST_REPLAY goes to ST_IDLE after the last tagged entry has been sent.

Top module: `hss_ctrl`

## Requirements
- R1: An instruction's position k counts the valid instructions after the accepted branch, starting at 1, and only positions 1..S are captured into hold slot k-1. S is the span annotation, clamped to the queue depth. Position k is dependent when k >= join offset + independent count. A branch whose span annotation is zero opens no hammock.
- R2: On a mispredicted resolve, sq_valid is high for exactly the next cycle. In that cycle, sq_mask bit i is set for each captured slot i that is not dependent.
- R3: On a correctly predicted resolve, sq_mask in the next cycle has a bit set for every captured slot. In that case there is no re-issue, no redirect and no map repair.
- R4: After a mispredicted resolve, the dependent captured instructions appear on ri_instr with ri_valid high, one per cycle and lowest slot first. They begin in the cycle after the resolve and run with no gaps.
- R5: redir_valid is high in the cycle after a mispredicted resolve only when the branch was predicted taken. redir_addr then equals the branch address plus the join offset.
- R6: On a mispredicted resolve, fix_valid pulses in the next cycle. For each register r (field r*PREG_W), fix_map holds the branch-snapshot value when the join-start snapshot differs from the branch snapshot, and holds the current-map value otherwise.
- R7: An annotated branch that arrives while a hammock is being tracked is captured as an ordinary instruction, and the hammock already open is unchanged.
- R8: A resolve event while no hammock is open produces no squash, re-issue, redirect or repair.
- R9: A resolve that arrives before the span is complete acts on the slots captured so far.
- R10: After reset, sq_valid, sq_mask, ri_valid, redir_valid and fix_valid are all zero.
- R11: sq_valid never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetched instruction valid |
| in_instr | input | INSTR_W | Fetched instruction payload |
| in_pc | input | ADDR_W | Address of the fetched instruction |
| in_is_br | input | 1 | Instruction is an annotated hammock branch |
| in_hsize | input | SZ_W | Span annotation (instructions after the branch) |
| in_nindep | input | SZ_W | Independent join instruction count |
| in_joff | input | SZ_W | Offset from branch to join start |
| in_pred_taken | input | 1 | Branch was predicted taken |
| res_valid | input | 1 | Branch resolve event |
| res_mispred | input | 1 | Resolve reports a misprediction |
| snap_br | input | NREG*PREG_W | Rename map snapshot at the branch |
| snap_join | input | NREG*PREG_W | Rename map snapshot at the join start |
| cur_map | input | NREG*PREG_W | Current rename map |
| sq_valid | output | 1 | Squash mask valid |
| sq_mask | output | QDEPTH | Hold slots to squash |
| ri_valid | output | 1 | Re-issue instruction valid |
| ri_instr | output | INSTR_W | Re-issued instruction |
| redir_valid | output | 1 | Fetch redirect valid |
| redir_addr | output | ADDR_W | Fetch redirect target |
| fix_valid | output | 1 | Repaired map valid |
| fix_map | output | NREG*PREG_W | Repaired rename map |

## Verification
The bound checker watches the timing relations on every cycle: a squash report only follows a resolve and lasts one cycle, and a redirect, a repair or the start of a re-issue burst only appears together with a squash report. It also checks that a correct resolve never redirects. The classification of positions and the exact mask bits can only be shown by the bench's scenarios. The same holds for the program order and payload of the re-issued instructions, the clamping of long spans, the ignored branches and resolves, the redirect address and the per-register map repair. For these, the bench predicts the values from the annotations and compares them at the ports.

// File: rtl/hss_pkg.sv
package hss_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_WAIT,
        ST_REPLAY
    } hss_state_e;
endpackage

// File: rtl/hss_span_class.sv
// Classifies a position inside the open hammock span.
module hss_span_class #(
    parameter int SZ_W = 4
) (
    input  logic [SZ_W-1:0] position,
    input  logic [SZ_W-1:0] span,
    input  logic [SZ_W-1:0] nindep,
    input  logic [SZ_W-1:0] joff,
    output logic            is_dep,
    output logic            is_last
);
    logic [SZ_W:0] dep_start;

    always_comb begin
        dep_start = {1'b0, joff} + {1'b0, nindep};
        is_dep    = ({1'b0, position} >= dep_start) && (position <= span);
        is_last   = (position == span);
    end
endmodule

// File: rtl/hss_holdq.sv
// Hold slots for the hammock span, with dependent tags and an in-order replay picker.
module hss_holdq #(
    parameter int QDEPTH  = 8,
    parameter int INSTR_W = 16,
    localparam int IDX_W  = $clog2(QDEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [INSTR_W-1:0] wr_data,
    input  logic               wr_tag,
    input  logic               load_pend,
    input  logic               pop,
    output logic [QDEPTH-1:0]  valid_vec,
    output logic [QDEPTH-1:0]  tag_vec,
    output logic [INSTR_W-1:0] head_data,
    output logic               pend_last
);
    logic [QDEPTH-1:0]  valid_q, tag_q, pend_q;
    logic [INSTR_W-1:0] slot_data [QDEPTH];

    for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
        logic [INSTR_W-1:0] d_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                d_q <= wr_data;
            end
        end
        assign slot_data[i] = d_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
        end else if (clr) begin
            valid_q <= '0;
            tag_q   <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (load_pend) begin
            pend_q <= valid_q & tag_q;
        end else if (pop) begin
            pend_q <= pend_q & (pend_q - 1'b1);
        end
    end

    always_comb begin
        logic found;
        found     = 1'b0;
        head_data = '0;
        for (int i = 0; i < QDEPTH; i++) begin
            if (pend_q[i] && !found) begin
                head_data = slot_data[i];
                found     = 1'b1;
            end
        end
        pend_last = ((pend_q & (pend_q - 1'b1)) == '0);
    end

    assign valid_vec = valid_q;
    assign tag_vec   = tag_q;
endmodule

// File: rtl/hss_mapfix.sv
// Per-register rename map repair from branch and join-start snapshots.
module hss_mapfix #(
    parameter int NREG   = 8,
    parameter int PREG_W = 5,
    localparam int MAP_W = NREG * PREG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [MAP_W-1:0] snap_br,
    input  logic [MAP_W-1:0] snap_join,
    input  logic [MAP_W-1:0] cur_map,
    output logic [MAP_W-1:0] fix_map
);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [PREG_W-1:0] ent_q;
        logic [PREG_W-1:0] br_v, jn_v, cu_v;
        assign br_v = snap_br[r*PREG_W +: PREG_W];
        assign jn_v = snap_join[r*PREG_W +: PREG_W];
        assign cu_v = cur_map[r*PREG_W +: PREG_W];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (cap) begin
                ent_q <= (jn_v != br_v) ? br_v : cu_v;
            end
        end
        assign fix_map[r*PREG_W +: PREG_W] = ent_q;
    end
endmodule

// File: rtl/hss_ctrl.sv
module hss_ctrl
    import hss_pkg::*;
#(
    parameter int QDEPTH  = 8,
    parameter int INSTR_W = 16,
    parameter int ADDR_W  = 16,
    parameter int SZ_W    = 4,
    parameter int NREG    = 8,
    parameter int PREG_W  = 5,
    localparam int IDX_W  = $clog2(QDEPTH),
    localparam int MAP_W  = NREG * PREG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    input  logic [ADDR_W-1:0]  in_pc,
    input  logic               in_is_br,
    input  logic [SZ_W-1:0]    in_hsize,
    input  logic [SZ_W-1:0]    in_nindep,
    input  logic [SZ_W-1:0]    in_joff,
    input  logic               in_pred_taken,
    input  logic               res_valid,
    input  logic               res_mispred,
    input  logic [MAP_W-1:0]   snap_br,
    input  logic [MAP_W-1:0]   snap_join,
    input  logic [MAP_W-1:0]   cur_map,
    output logic               sq_valid,
    output logic [QDEPTH-1:0]  sq_mask,
    output logic               ri_valid,
    output logic [INSTR_W-1:0] ri_instr,
    output logic               redir_valid,
    output logic [ADDR_W-1:0]  redir_addr,
    output logic               fix_valid,
    output logic [MAP_W-1:0]   fix_map
);
    hss_state_e st_q, st_d;

    logic [SZ_W-1:0]   span_q, nind_q, joff_q, pos_q;
    logic [ADDR_W-1:0] pc_q;
    logic              ptk_q;

    logic [SZ_W-1:0]   span_clamped;
    logic [SZ_W-1:0]   position;
    logic              start_hm, tracking, resolve, cap_ins;
    logic              pos_dep, pos_last;

    logic [QDEPTH-1:0]  valid_vec, tag_vec;
    logic [INSTR_W-1:0] head_data;
    logic               pend_last;

    logic               sq_valid_q, redir_valid_q, fix_valid_q;
    logic [QDEPTH-1:0]  sq_mask_q;
    logic [ADDR_W-1:0]  redir_addr_q;

    always_comb begin
        span_clamped = (in_hsize > SZ_W'(QDEPTH)) ? SZ_W'(QDEPTH) : in_hsize;
        start_hm     = (st_q == ST_IDLE) && in_valid && in_is_br && (in_hsize != '0);
        tracking     = (st_q == ST_COLLECT) || (st_q == ST_WAIT);
        resolve      = tracking && res_valid;
        cap_ins      = (st_q == ST_COLLECT) && in_valid && !res_valid;
        position     = pos_q + 1'b1;
    end

    hss_span_class #(.SZ_W(SZ_W)) u_class (
        .position (position),
        .span     (span_q),
        .nindep   (nind_q),
        .joff     (joff_q),
        .is_dep   (pos_dep),
        .is_last  (pos_last)
    );

    hss_holdq #(.QDEPTH(QDEPTH), .INSTR_W(INSTR_W)) u_holdq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (resolve),
        .wr_en     (cap_ins),
        .wr_idx    (pos_q[IDX_W-1:0]),
        .wr_data   (in_instr),
        .wr_tag    (pos_dep),
        .load_pend (resolve && res_mispred),
        .pop       (st_q == ST_REPLAY),
        .valid_vec (valid_vec),
        .tag_vec   (tag_vec),
        .head_data (head_data),
        .pend_last (pend_last)
    );

    hss_mapfix #(.NREG(NREG), .PREG_W(PREG_W)) u_mapfix (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (resolve && res_mispred),
        .snap_br   (snap_br),
        .snap_join (snap_join),
        .cur_map   (cur_map),
        .fix_map   (fix_map)
    );

    // Next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_hm) st_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (res_valid) begin
                    st_d = (res_mispred && |(valid_vec & tag_vec)) ? ST_REPLAY : ST_IDLE;
                end else if (cap_ins && pos_last) begin
                    st_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (res_valid) begin
                    st_d = (res_mispred && |(valid_vec & tag_vec)) ? ST_REPLAY : ST_IDLE;
                end
            end
            ST_REPLAY: begin
                if (pend_last) st_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Hammock context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= '0;
            nind_q <= '0;
            joff_q <= '0;
            pos_q  <= '0;
            pc_q   <= '0;
            ptk_q  <= 1'b0;
        end else if (start_hm) begin
            span_q <= span_clamped;
            nind_q <= in_nindep;
            joff_q <= in_joff;
            pos_q  <= '0;
            pc_q   <= in_pc;
            ptk_q  <= in_pred_taken;
        end else if (cap_ins) begin
            pos_q <= position;
        end
    end

    // Resolve responses, one cycle after the event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_valid_q    <= 1'b0;
            sq_mask_q     <= '0;
            redir_valid_q <= 1'b0;
            redir_addr_q  <= '0;
            fix_valid_q   <= 1'b0;
        end else begin
            sq_valid_q    <= resolve;
            sq_mask_q     <= !resolve   ? '0 :
                             res_mispred ? (valid_vec & ~tag_vec) : valid_vec;
            redir_valid_q <= resolve && res_mispred && ptk_q;
            redir_addr_q  <= (resolve && res_mispred && ptk_q) ?
                             (pc_q + ADDR_W'(joff_q)) : '0;
            fix_valid_q   <= resolve && res_mispred;
        end
    end

    // Outputs
    always_comb begin
        sq_valid    = sq_valid_q;
        sq_mask     = sq_mask_q;
        redir_valid = redir_valid_q;
        redir_addr  = redir_addr_q;
        fix_valid   = fix_valid_q;
        ri_valid    = (st_q == ST_REPLAY);
        ri_instr    = (st_q == ST_REPLAY) ? head_data : '0;
    end
endmodule

// File: rtl/hss_ctrl_chk.sv
module hss_ctrl_chk #(
    parameter int QDEPTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic              sq_valid,
    input logic [QDEPTH-1:0] sq_mask,
    input logic              ri_valid,
    input logic              redir_valid,
    input logic              fix_valid
);
    AST_SQ_FOLLOWS_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> $past(res_valid)); // R2
    AST_SQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> !sq_valid); // R11
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_valid |-> (sq_mask == '0)); // R2
    AST_REDIR_WITH_SQ: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (sq_valid && fix_valid)); // R5
    AST_FIX_WITH_SQ: assert property (@(posedge clk) disable iff (!rst_n)
        fix_valid |-> sq_valid); // R6
    AST_RI_OPENS_WITH_SQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_valid && !$past(ri_valid)) |-> (sq_valid && fix_valid)); // R4
    AST_CORRECT_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !fix_valid) |-> (!redir_valid && !ri_valid)); // R3
endmodule

bind hss_ctrl hss_ctrl_chk #(.QDEPTH(QDEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_valid   (res_valid),
    .sq_valid    (sq_valid),
    .sq_mask     (sq_mask),
    .ri_valid    (ri_valid),
    .redir_valid (redir_valid),
    .fix_valid   (fix_valid)
);

// File: tb/sim_hss_ctrl.sv
module sim_hss_ctrl;
    localparam int QD = 8, IW = 16, AW = 16, SW = 4, NR = 8, PW = 5, MW = NR * PW;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          in_valid = 0, in_is_br = 0, in_pred_taken = 0;
    logic [IW-1:0] in_instr = '0;
    logic [AW-1:0] in_pc = '0;
    logic [SW-1:0] in_hsize = '0, in_nindep = '0, in_joff = '0;
    logic          res_valid = 0, res_mispred = 0;
    logic [MW-1:0] snap_br, snap_join, cur_map;
    logic          sq_valid, ri_valid, redir_valid, fix_valid;
    logic [QD-1:0] sq_mask;
    logic [IW-1:0] ri_instr;
    logic [AW-1:0] redir_addr;
    logic [MW-1:0] fix_map;

    int checks = 0, failures = 0;
    logic [IW-1:0] exp_q[$];

    always #5 clk = ~clk;

    hss_ctrl u0 (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares re-issued instructions against the scoreboard (R4)
    always @(negedge clk) begin
        if (rst_n && ri_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R4", "unexpected reissue", 64'(ri_instr), 64'h0);
            end else begin
                logic [IW-1:0] e;
                e = exp_q.pop_front();
                check(ri_instr == e, "R4", "reissue order", 64'(ri_instr), 64'(e));
            end
        end
    end

    task automatic fetch(input logic br, input logic [IW-1:0] ins, input logic [AW-1:0] pc,
                         input logic [SW-1:0] hs, input logic [SW-1:0] ni,
                         input logic [SW-1:0] jo, input logic pt);
        @(negedge clk);
        in_valid = 1; in_is_br = br; in_instr = ins; in_pc = pc;
        in_hsize = hs; in_nindep = ni; in_joff = jo; in_pred_taken = pt;
        @(posedge clk); #1;
        in_valid = 0; in_is_br = 0;
    endtask

    task automatic resolve(input logic mis);
        @(negedge clk);
        res_valid = 1; res_mispred = mis;
        @(posedge clk); #1;
        res_valid = 0; res_mispred = 0;
        @(negedge clk);
    endtask

    task automatic expect_sq(input string req, input logic v, input logic [QD-1:0] m,
                             input logic rv, input logic [AW-1:0] ra, input logic fv);
        check(sq_valid == v, req, "sq_valid", 64'(sq_valid), 64'(v));
        check(sq_mask == m, req, "sq_mask", 64'(sq_mask), 64'(m));
        check(redir_valid == rv, "R5", "redir_valid", 64'(redir_valid), 64'(rv));
        if (rv) check(redir_addr == ra, "R5", "redir_addr", 64'(redir_addr), 64'(ra));
        check(fix_valid == fv, "R6", "fix_valid", 64'(fix_valid), 64'(fv));
    endtask

    task automatic drain(input string req);
        @(negedge clk);
        check(sq_valid == 0, "R11", "sq_valid second cycle", 64'(sq_valid), 64'h0);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, req, "reissue count left", 64'(exp_q.size()), 64'h0);
    endtask

    function automatic logic [MW-1:0] exp_fix();
        logic [MW-1:0] f;
        for (int r = 0; r < NR; r++) begin
            f[r*PW +: PW] = (snap_join[r*PW +: PW] != snap_br[r*PW +: PW]) ?
                            snap_br[r*PW +: PW] : cur_map[r*PW +: PW];
        end
        return f;
    endfunction

    initial begin
        #2_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            snap_br[r*PW +: PW]   = PW'(r);
            snap_join[r*PW +: PW] = (r == 2 || r == 5) ? PW'(r + 8) : PW'(r);
            cur_map[r*PW +: PW]   = PW'(r + 16);
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check(sq_valid == 0, "R10", "sq_valid", 64'(sq_valid), 0);
        check(sq_mask == 0, "R10", "sq_mask", 64'(sq_mask), 0);
        check(ri_valid == 0, "R10", "ri_valid", 64'(ri_valid), 0);
        check(redir_valid == 0 && fix_valid == 0, "R10", "redir/fix", 64'({redir_valid, fix_valid}), 0);
        rst_n = 1'b1;

        // R1/R2/R5/R6: span 5, join at 3, one independent, predicted taken
        fetch(1, 16'h0B00, 16'h0100, 4'd5, 4'd1, 4'd3, 1);
        for (int k = 1; k <= 5; k++) fetch(0, 16'hA000 + IW'(k), '0, '0, '0, '0, 0);
        exp_q.push_back(16'hA004); exp_q.push_back(16'hA005);
        resolve(1);
        expect_sq("R2", 1, 8'b0000_0111, 1, 16'h0103, 1);
        check(fix_map == exp_fix(), "R6", "fix_map", 64'(fix_map), 64'(exp_fix()));
        drain("R4");

        // R3: correct prediction purges every captured slot
        fetch(1, 16'h0B01, 16'h0180, 4'd4, 4'd1, 4'd2, 1);
        for (int k = 1; k <= 4; k++) fetch(0, 16'hB000 + IW'(k), '0, '0, '0, '0, 0);
        resolve(0);
        expect_sq("R3", 1, 8'b0000_1111, 0, '0, 0);
        drain("R3");

        // R4/R5: predicted not taken, many dependents, no redirect
        fetch(1, 16'h0B02, 16'h0300, 4'd6, 4'd0, 4'd2, 0);
        for (int k = 1; k <= 6; k++) fetch(0, 16'hF000 + IW'(k), '0, '0, '0, '0, 0);
        for (int k = 2; k <= 6; k++) exp_q.push_back(16'hF000 + IW'(k));
        resolve(1);
        expect_sq("R2", 1, 8'b0000_0001, 0, '0, 1);
        drain("R4");

        // R8: resolve with nothing open
        resolve(1);
        expect_sq("R8", 0, 8'h00, 0, '0, 0);
        drain("R8");

        // R7: nested annotated branch treated as ordinary
        fetch(1, 16'h0B03, 16'h0200, 4'd3, 4'd0, 4'd2, 1);
        fetch(1, 16'hC001, 16'h0201, 4'd2, 4'd0, 4'd1, 0);
        fetch(0, 16'hC002, '0, '0, '0, '0, 0);
        fetch(0, 16'hC003, '0, '0, '0, '0, 0);
        exp_q.push_back(16'hC002); exp_q.push_back(16'hC003);
        resolve(1);
        expect_sq("R7", 1, 8'b0000_0001, 1, 16'h0202, 1);
        drain("R7");

        // R9: resolve before the span is complete
        fetch(1, 16'h0B04, 16'h0400, 4'd6, 4'd1, 4'd1, 0);
        for (int k = 1; k <= 3; k++) fetch(0, 16'hD000 + IW'(k), '0, '0, '0, '0, 0);
        exp_q.push_back(16'hD002); exp_q.push_back(16'hD003);
        resolve(1);
        expect_sq("R9", 1, 8'b0000_0001, 0, '0, 1);
        drain("R9");

        // R1: span clamped to queue depth, extra instructions not captured
        fetch(1, 16'h0B05, 16'h0500, 4'd15, 4'd7, 4'd1, 0);
        for (int k = 1; k <= 10; k++) fetch(0, 16'hE000 + IW'(k), '0, '0, '0, '0, 0);
        exp_q.push_back(16'hE008);
        resolve(1);
        expect_sq("R1", 1, 8'b0111_1111, 0, '0, 1);
        drain("R1");

        // R1: zero span opens no hammock
        fetch(1, 16'h0B06, 16'h0600, 4'd0, 4'd0, 4'd1, 1);
        fetch(0, 16'h9001, '0, '0, '0, '0, 0);
        resolve(1);
        expect_sq("R1", 0, 8'h00, 0, '0, 0);
        drain("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule